// File: doc/BRIEF.md
# Trace Flush and Stop Controller

This block is the control engine that sits in front of a trace stream formatter. It holds one control register and watches three event sources: an external flush request pin, an external trigger pin and a loadable trigger countdown counter. Flush requests can come from three places: the external pin, a trigger event and a manual bit in the register. The block ranks these requests and serves them one at a time. It does this over a request/acknowledge handshake with the upstream trace source, and a `flushSrc` code says which source the current flush belongs to.

The block also raises a one-cycle trigger indication from any of three enabled causes, and it decides when the formatter stops. While stopped, the block keeps the trace input ready high and drops every beat it accepts, so a shared upstream source never stalls. The formatter starts stopped after reset. A `runReq` pulse starts it, and a stop event halts it again. The mode bits select bypass, formatted or continuous output. They only take a write while the block is stopped.

Top module: `traceFlushCtl`

## Requirements
- R1: Out of reset every register field reads 0. The implemented fields are bit 0 (format enable), bit 1 (continuous enable), bit 4 (external flush enable), bit 5 (flush on trigger event), bit 6 (manual flush), bit 8 (indicate on trigger input), bit 9 (indicate on trigger event), bit 10 (indicate on flush completion), bit 12 (stop on flush completion) and bit 13 (stop on trigger event). All other bits read 0 and ignore writes.
- R2: `fmtMode` is 00 when mode bits[1:0] are 00 (bypass), 01 when they are 01 (formatted), and 10 when they are 10 or 11 (continuous). A write changes bits[1:0] only while `stopped` is 1; otherwise they keep their value.
- R3: Writing 1 to bit 6 requests a manual flush. The bit reads 1 while that flush is pending or in service and reads 0 from the cycle after its acknowledge.
- R4: When more than one flush request is pending, the external flush is served first, then the trigger-generated flush, then the manual flush. `flushSrc` codes are 1 for external, 2 for trigger and 3 for manual.
- R5: Once raised, `flushReq` and `flushSrc` stay constant until `flushAck` is seen. New requests never preempt the flush in service. `flushReq` is 0 in the cycle after the acknowledge, and `flushSrc` reads 0 when no flush is in service.
- R6: A loaded nonzero counter decrements on each accepted beat, and a trigger event occurs on the beat that takes it from 1 to 0. While the counter is 0, a rising edge of the synchronized trigger input is a trigger event.
- R7: `trigOut` pulses for one cycle on each enabled cause: a trigger input edge (bit 8), a trigger event (bit 9) or a flush completion (bit 10). Coincident causes give a single pulse, and a disabled cause gives none.
- R8: With bit 13 set, a trigger event sets `stopped` in the same edge that the event completes.
- R9: With bit 12 set, the acknowledge of a flush sets `stopped`.
- R10: `stopped` is 1 after reset and is cleared by `runReq`. While `stopped` is 1, `traceReady` is 1 and `beatKeep` is 0 whatever `fmtReady` is. While running, `traceReady` follows `fmtReady`.
- R11: A rising edge of the external flush input creates a pending flush only while bit 4 is set. An edge seen while bit 4 is clear is not remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 16 | Control register write value |
| regRdData | output | 16 | Control register read value |
| runReq | input | 1 | Pulse that starts the formatter |
| cntLoadEn | input | 1 | Load strobe for the trigger countdown |
| cntLoadVal | input | CNT_W | Trigger countdown load value |
| flushInAsync | input | 1 | External flush request, asynchronous |
| trigInAsync | input | 1 | External trigger input, asynchronous |
| flushReq | output | 1 | Flush request to the trace source |
| flushAck | input | 1 | Flush completion from the trace source |
| flushSrc | output | 2 | Source of the flush in service (0 none, 1 external, 2 trigger, 3 manual) |
| traceValid | input | 1 | Upstream beat valid |
| fmtReady | input | 1 | Formatter can take a beat |
| traceReady | output | 1 | Ready returned upstream |
| beatKeep | output | 1 | Accepted beat is passed to the formatter |
| stopped | output | 1 | Formatter stopped status |
| trigOut | output | 1 | Trigger indication pulse |
| fmtMode | output | 2 | Formatting mode (00 bypass, 01 formatted, 10 continuous) |

## Verification
The hardest case to reach is having all three flush sources pending at once while a flush is still in service. Only that state shows the service order and the absence of preemption. The bench starts a manual flush and holds the acknowledge low. During that window it pulses the external flush pin and raises the trigger pin while the counter is zero, so both requests must pass through the synchronizers and wait. Then it acknowledges flush by flush and reads `flushSrc` and the manual bit between steps. A second round, started by an external flush, shows that the trigger flush goes ahead of the manual one.

// File: rtl/traceFlushPkg.sv
package traceFlushPkg;

  localparam int CTRL_W = 16;

  // control register bit positions
  localparam int B_FMT      = 0;
  localparam int B_CONT     = 1;
  localparam int B_FL_EXT   = 4;
  localparam int B_FL_TRIG  = 5;
  localparam int B_FL_MAN   = 6;
  localparam int B_IND_IN   = 8;
  localparam int B_IND_EVT  = 9;
  localparam int B_IND_FL   = 10;
  localparam int B_STOP_FL  = 12;
  localparam int B_STOP_TRG = 13;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_TRIG = 2'd2,
    SRC_MAN  = 2'd3
  } flushSrc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_GAP  = 2'd2
  } arbState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic cntDec;
  } dpStrobe_t;

  // datapath -> control events
  typedef struct packed {
    logic flushInRise;
    logic trigInRise;
    logic trigEvent;
  } dpEvent_t;

endpackage

// File: rtl/traceSyncEdge.sv
module traceSyncEdge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-1:0], asyncIn};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/traceFlushDp.sv
module traceFlushDp
  import traceFlushPkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flushInAsync,
  input  logic             trigInAsync,
  input  logic             cntLoadEn,
  input  logic [CNT_W-1:0] cntLoadVal,
  input  dpStrobe_t        strobe,
  output dpEvent_t         evt
);
  localparam int NUM_SYNC = 2;

  logic [NUM_SYNC-1:0] asyncVec;
  logic [NUM_SYNC-1:0] riseVec;
  logic [CNT_W-1:0]    cnt;

  assign asyncVec = {trigInAsync, flushInAsync};

  for (genvar i = 0; i < NUM_SYNC; i++) begin : gSync
    traceSyncEdge #(.STAGES(SYNC_STAGES)) uSync (
      .clk    (clk),
      .rstN   (rstN),
      .asyncIn(asyncVec[i]),
      .rise   (riseVec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN)                              cnt <= '0;
    else if (cntLoadEn)                     cnt <= cntLoadVal;
    else if (strobe.cntDec && cnt != '0)    cnt <= cnt - CNT_W'(1);
  end

  always_comb begin
    evt.flushInRise = riseVec[0];
    evt.trigInRise  = riseVec[1];
    evt.trigEvent   = !cntLoadEn &&
                      ((cnt == CNT_W'(1) && strobe.cntDec) ||
                       (cnt == '0 && riseVec[1]));
  end

  // R6: a running count steps down by one per accepted beat
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!cntLoadEn && strobe.cntDec && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1));

  // R6: a loaded value is taken as is
  p_cnt_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    cntLoadEn |=> cnt == $past(cntLoadVal));
endmodule

// File: rtl/traceFlushCtrl.sv
module traceFlushCtrl
  import traceFlushPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [CTRL_W-1:0] regWrData,
  output logic [CTRL_W-1:0] regRdData,
  input  logic              runReq,
  input  logic              flushAck,
  input  logic              traceValid,
  input  logic              fmtReady,
  input  dpEvent_t          evt,
  output dpStrobe_t         strobe,
  output logic              flushReq,
  output logic [1:0]        flushSrc,
  output logic              traceReady,
  output logic              beatKeep,
  output logic              stopped,
  output logic              trigOut,
  output logic [1:0]        fmtMode
);
  logic [1:0] modeBits;
  logic enFlExt, enFlTrig, manBit;
  logic indIn, indEvt, indFl, stopFl, stopTrg;
  logic pendExt, pendTrig;
  logic wrMan, grant, flushDone;
  arbState_e state, nextState;
  flushSrc_e srcReg, grantSrc;

  assign wrMan = regWrEn & regWrData[B_FL_MAN];

  // configuration fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeBits <= 2'b00;
      enFlExt  <= 1'b0;
      enFlTrig <= 1'b0;
      indIn    <= 1'b0;
      indEvt   <= 1'b0;
      indFl    <= 1'b0;
      stopFl   <= 1'b0;
      stopTrg  <= 1'b0;
    end else if (regWrEn) begin
      if (stopped) modeBits <= {regWrData[B_CONT], regWrData[B_FMT]};
      enFlExt  <= regWrData[B_FL_EXT];
      enFlTrig <= regWrData[B_FL_TRIG];
      indIn    <= regWrData[B_IND_IN];
      indEvt   <= regWrData[B_IND_EVT];
      indFl    <= regWrData[B_IND_FL];
      stopFl   <= regWrData[B_STOP_FL];
      stopTrg  <= regWrData[B_STOP_TRG];
    end
  end

  always_comb begin
    regRdData             = '0;
    regRdData[B_FMT]      = modeBits[0];
    regRdData[B_CONT]     = modeBits[1];
    regRdData[B_FL_EXT]   = enFlExt;
    regRdData[B_FL_TRIG]  = enFlTrig;
    regRdData[B_FL_MAN]   = manBit;
    regRdData[B_IND_IN]   = indIn;
    regRdData[B_IND_EVT]  = indEvt;
    regRdData[B_IND_FL]   = indFl;
    regRdData[B_STOP_FL]  = stopFl;
    regRdData[B_STOP_TRG] = stopTrg;
  end

  always_comb begin
    if (modeBits[1])      fmtMode = 2'b10;
    else if (modeBits[0]) fmtMode = 2'b01;
    else                  fmtMode = 2'b00;
  end

  // flush arbitration
  always_comb begin
    if (pendExt)       grantSrc = SRC_EXT;
    else if (pendTrig) grantSrc = SRC_TRIG;
    else if (manBit)   grantSrc = SRC_MAN;
    else               grantSrc = SRC_NONE;
  end

  assign grant     = (state == ST_IDLE) && (grantSrc != SRC_NONE);
  assign flushDone = (state == ST_REQ) && flushAck;

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE: if (grant) nextState = ST_REQ;
      ST_REQ:  if (flushAck) nextState = ST_GAP;
      ST_GAP:  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      srcReg   <= SRC_NONE;
      pendExt  <= 1'b0;
      pendTrig <= 1'b0;
      manBit   <= 1'b0;
    end else begin
      state    <= nextState;
      if (grant) srcReg <= grantSrc;
      pendExt  <= (pendExt  & ~(grant && grantSrc == SRC_EXT))
                | (evt.flushInRise & enFlExt);
      pendTrig <= (pendTrig & ~(grant && grantSrc == SRC_TRIG))
                | (evt.trigEvent & enFlTrig);
      if (wrMan)                                  manBit <= 1'b1;
      else if (flushDone && srcReg == SRC_MAN)    manBit <= 1'b0;
    end
  end

  assign flushReq = (state == ST_REQ);
  assign flushSrc = (state == ST_REQ) ? srcReg : SRC_NONE;

  // stop, ready and trigger indication
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopped <= 1'b1;
      trigOut <= 1'b0;
    end else begin
      if ((stopTrg & evt.trigEvent) | (stopFl & flushDone)) stopped <= 1'b1;
      else if (runReq)                                      stopped <= 1'b0;
      trigOut <= (indIn & evt.trigInRise) | (indEvt & evt.trigEvent)
               | (indFl & flushDone);
    end
  end

  assign traceReady    = stopped | fmtReady;
  assign beatKeep      = traceValid & fmtReady & ~stopped;
  assign strobe.cntDec = beatKeep;

  // R5: request and source hold until acknowledged
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (flushReq && !flushAck) |=> (flushReq && $stable(flushSrc)));

  // R5: request stays low the cycle after it drops
  p_req_gap_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flushReq) |=> !flushReq);

  // R4: a pending external flush is always served next
  p_ext_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && pendExt) |=> flushSrc == SRC_EXT);

  // R3: manual bit clears after its flush is acknowledged
  p_man_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (flushDone && srcReg == SRC_MAN && !wrMan) |=> !regRdData[B_FL_MAN]);

  // R2: mode locked while running
  p_mode_lock_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stopped |=> $stable(fmtMode));

  // R10: stopped keeps input ready and discards beats
  p_stop_ready_r10: assert property (@(posedge clk) disable iff (!rstN)
    stopped |-> (traceReady && !beatKeep));
endmodule

// File: rtl/traceFlushCtl.sv
module traceFlushCtl
  import traceFlushPkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [CTRL_W-1:0] regWrData,
  output logic [CTRL_W-1:0] regRdData,
  input  logic              runReq,
  input  logic              cntLoadEn,
  input  logic [CNT_W-1:0]  cntLoadVal,
  input  logic              flushInAsync,
  input  logic              trigInAsync,
  output logic              flushReq,
  input  logic              flushAck,
  output logic [1:0]        flushSrc,
  input  logic              traceValid,
  input  logic              fmtReady,
  output logic              traceReady,
  output logic              beatKeep,
  output logic              stopped,
  output logic              trigOut,
  output logic [1:0]        fmtMode
);
  dpStrobe_t strobe;
  dpEvent_t  evt;

  traceFlushDp #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .flushInAsync(flushInAsync),
    .trigInAsync (trigInAsync),
    .cntLoadEn   (cntLoadEn),
    .cntLoadVal  (cntLoadVal),
    .strobe      (strobe),
    .evt         (evt)
  );

  traceFlushCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .runReq    (runReq),
    .flushAck  (flushAck),
    .traceValid(traceValid),
    .fmtReady  (fmtReady),
    .evt       (evt),
    .strobe    (strobe),
    .flushReq  (flushReq),
    .flushSrc  (flushSrc),
    .traceReady(traceReady),
    .beatKeep  (beatKeep),
    .stopped   (stopped),
    .trigOut   (trigOut),
    .fmtMode   (fmtMode)
  );
endmodule

// File: tb/sim_traceFlushCtl.sv
module sim_traceFlushCtl;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN;
  logic regWrEn;
  logic [15:0] regWrData, regRdData;
  logic runReq, cntLoadEn;
  logic [CNT_W-1:0] cntLoadVal;
  logic flushInAsync, trigInAsync, flushReq, flushAck;
  logic [1:0] flushSrc, fmtMode;
  logic traceValid, fmtReady, traceReady, beatKeep, stopped, trigOut;

  int checks = 0;
  int failures = 0;
  int trigCount = 0;

  always #5 clk = ~clk;

  traceFlushCtl #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .runReq(runReq), .cntLoadEn(cntLoadEn),
    .cntLoadVal(cntLoadVal), .flushInAsync(flushInAsync),
    .trigInAsync(trigInAsync), .flushReq(flushReq), .flushAck(flushAck),
    .flushSrc(flushSrc), .traceValid(traceValid), .fmtReady(fmtReady),
    .traceReady(traceReady), .beatKeep(beatKeep), .stopped(stopped),
    .trigOut(trigOut), .fmtMode(fmtMode)
  );

  always @(negedge clk) if (rstN && trigOut) trigCount++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; regWrEn = 0; regWrData = '0; runReq = 0; cntLoadEn = 0;
    cntLoadVal = '0; flushInAsync = 0; trigInAsync = 0; flushAck = 0;
    traceValid = 0; fmtReady = 0;
    cyc(3);
    rstN = 1'b1;
    cyc(2);
    trigCount = 0;
  endtask

  task automatic wrReg(input logic [15:0] d);
    regWrEn = 1'b1; regWrData = d;
    cyc(1);
    regWrEn = 1'b0;
  endtask

  task automatic run();
    runReq = 1'b1; cyc(1); runReq = 1'b0;
  endtask

  task automatic loadCnt(input int v);
    cntLoadEn = 1'b1; cntLoadVal = CNT_W'(v); cyc(1); cntLoadEn = 1'b0;
  endtask

  task automatic beats(input int n);
    fmtReady = 1'b1; traceValid = 1'b1; cyc(n); traceValid = 1'b0;
  endtask

  task automatic pulseTrig();
    trigInAsync = 1'b1; cyc(4); trigInAsync = 1'b0; cyc(4);
  endtask

  task automatic pulseFlushIn();
    flushInAsync = 1'b1; cyc(4); flushInAsync = 1'b0; cyc(4);
  endtask

  task automatic waitReq(input string req);
    int n = 0;
    while (!flushReq && n < 30) begin cyc(1); n++; end
    chk(flushReq == 1'b1, req, int'(flushReq), 1);
  endtask

  // acknowledge, then the request must already be low (R5)
  task automatic ackFlush();
    flushAck = 1'b1; cyc(1); flushAck = 1'b0;
    chk(flushReq == 1'b0, "R5 drop after ack", int'(flushReq), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int mask;
    int pos[10] = '{0, 1, 4, 5, 6, 8, 9, 10, 12, 13};

    // R1 reset state and register layout
    doReset();
    chk(regRdData == 16'h0, "R1 reset read", int'(regRdData), 0);
    chk(stopped == 1'b1, "R10 reset stopped", int'(stopped), 1);
    chk(flushReq == 1'b0 && trigOut == 1'b0, "R5 reset idle", int'(flushReq), 0);
    chk(fmtMode == 2'b00, "R2 reset mode", int'(fmtMode), 0);
    chk(flushSrc == 2'd0, "R5 reset src", int'(flushSrc), 0);
    mask = 0;
    foreach (pos[i]) mask |= (1 << pos[i]);
    wrReg(16'hFFBF);
    chk(int'(regRdData) == (16'hFFBF & mask), "R1 readback", int'(regRdData), 16'hFFBF & mask);

    // R2 mode sweep while stopped, then lock while running
    doReset();
    for (int w = 0; w < 4; w++) begin
      wrReg(16'(w));
      chk(int'(fmtMode) == ((w == 0) ? 0 : (w == 1) ? 1 : 2), "R2 mode", int'(fmtMode),
          (w == 0) ? 0 : (w == 1) ? 1 : 2);
      chk(int'(regRdData[1:0]) == w, "R2 readback", int'(regRdData[1:0]), w);
    end
    run();
    wrReg(16'h0001);
    chk(fmtMode == 2'b10, "R2 locked", int'(fmtMode), 2);
    chk(regRdData[1:0] == 2'b11, "R2 locked bits", int'(regRdData[1:0]), 3);

    // R3 manual flush
    doReset();
    wrReg(16'h0040);
    chk(regRdData[6] == 1'b1, "R3 pending", int'(regRdData[6]), 1);
    waitReq("R3 request");
    chk(flushSrc == 2'd3, "R3 src", int'(flushSrc), 3);
    cyc(3);
    chk(flushReq == 1'b1 && regRdData[6] == 1'b1, "R5 hold", int'(flushReq), 1);
    ackFlush();
    chk(regRdData[6] == 1'b0, "R3 cleared", int'(regRdData[6]), 0);
    cyc(5);
    chk(flushReq == 1'b0, "R3 no repeat", int'(flushReq), 0);

    // R4 priority, round 1: manual in service, external and trigger queue
    doReset();
    wrReg(16'h0070);
    waitReq("R4 first");
    chk(flushSrc == 2'd3, "R4 manual first", int'(flushSrc), 3);
    pulseFlushIn();
    pulseTrig();
    chk(flushReq == 1'b1 && flushSrc == 2'd3, "R5 no preempt", int'(flushSrc), 3);
    ackFlush();
    waitReq("R4 second");
    chk(flushSrc == 2'd1, "R4 ext before trig", int'(flushSrc), 1);
    ackFlush();
    waitReq("R4 third");
    chk(flushSrc == 2'd2, "R4 trig third", int'(flushSrc), 2);
    ackFlush();
    cyc(6);
    chk(flushReq == 1'b0, "R4 queue empty", int'(flushReq), 0);
    // round 2: external in service, manual and trigger queue
    pulseFlushIn();
    waitReq("R4 r2 first");
    chk(flushSrc == 2'd1, "R4 r2 ext", int'(flushSrc), 1);
    wrReg(16'h0070);
    pulseTrig();
    ackFlush();
    waitReq("R4 r2 second");
    chk(flushSrc == 2'd2, "R4 trig before manual", int'(flushSrc), 2);
    chk(regRdData[6] == 1'b1, "R4 manual still pending", int'(regRdData[6]), 1);
    ackFlush();
    waitReq("R4 r2 third");
    chk(flushSrc == 2'd3, "R4 manual last", int'(flushSrc), 3);
    ackFlush();
    chk(regRdData[6] == 1'b0, "R3 cleared r2", int'(regRdData[6]), 0);

    // R6 countdown sweep
    for (int n = 1; n <= 6; n++) begin
      doReset();
      wrReg(16'h0200);
      run();
      loadCnt(n);
      trigCount = 0;
      if (n > 1) beats(n - 1);
      cyc(2);
      chk(trigCount == 0, "R6 early", trigCount, 0);
      beats(1);
      cyc(2);
      chk(trigCount == 1, "R6 on terminal beat", trigCount, 1);
    end

    // R7 indication enable sweep
    for (int en = 0; en < 8; en++) begin
      doReset();
      wrReg(16'(en << 8));
      run();
      trigCount = 0;
      pulseTrig();
      cyc(2);
      chk(trigCount == (((en & 3) != 0) ? 1 : 0), "R7 trig at zero count", trigCount,
          ((en & 3) != 0) ? 1 : 0);
      loadCnt(5);
      trigCount = 0;
      pulseTrig();
      cyc(2);
      chk(trigCount == (en & 1), "R7 trig input only", trigCount, en & 1);
      trigCount = 0;
      wrReg(16'((en << 8) | 16'h0040));
      waitReq("R7 flush");
      ackFlush();
      cyc(2);
      chk(trigCount == ((en >> 2) & 1), "R7 flush completion", trigCount, (en >> 2) & 1);
    end

    // R8 stop on trigger, R10 ready behaviour
    doReset();
    wrReg(16'h2000);
    run();
    chk(stopped == 1'b0, "R10 run clears", int'(stopped), 0);
    fmtReady = 1'b0;
    cyc(1);
    chk(traceReady == 1'b0, "R10 running follows", int'(traceReady), 0);
    loadCnt(2);
    beats(1);
    chk(stopped == 1'b0, "R8 not yet", int'(stopped), 0);
    beats(1);
    chk(stopped == 1'b1, "R8 stop on trigger", int'(stopped), 1);
    fmtReady = 1'b0; traceValid = 1'b1;
    cyc(1);
    chk(traceReady == 1'b1, "R10 ready when stopped", int'(traceReady), 1);
    fmtReady = 1'b1;
    cyc(1);
    chk(beatKeep == 1'b0, "R10 discard", int'(beatKeep), 0);
    traceValid = 1'b0;

    // R9 stop on flush completion
    doReset();
    wrReg(16'h1000);
    run();
    wrReg(16'h1040);
    waitReq("R9 request");
    chk(stopped == 1'b0, "R9 before ack", int'(stopped), 0);
    ackFlush();
    chk(stopped == 1'b1, "R9 stop after ack", int'(stopped), 1);

    // R11 external enable gate
    doReset();
    pulseFlushIn();
    cyc(4);
    chk(flushReq == 1'b0, "R11 disabled", int'(flushReq), 0);
    wrReg(16'h0010);
    cyc(6);
    chk(flushReq == 1'b0, "R11 not remembered", int'(flushReq), 0);
    pulseFlushIn();
    waitReq("R11 enabled");
    chk(flushSrc == 2'd1, "R11 src", int'(flushSrc), 1);
    ackFlush();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule